// File: doc/BRIEF.md
# Dual-Granularity Transmit/Receive Byte FIFO Pair

This block buffers bytes between a processor bus and a serial shift engine. It has two byte-wide FIFOs. The transmit FIFO is filled from the bus, either one byte or four bytes per access, and is drained one byte at a time by the engine. The receive FIFO is filled one byte at a time by the engine and is drained by the bus, either one byte or four bytes per access. Every data path is a valid/ready stream. A transfer takes place on a clock edge where valid and ready are both high. Each port's ready or valid depends only on FIFO occupancy and on the rules listed below.

The block also produces the flags that software polls. A granularity mode bit moves the full, empty and available thresholds between one byte and four bytes. This lets firmware that moves whole words poll once per word. The mode bit is set and cleared only by two pulse commands. The block also holds two sticky completion flags, which are set by pulses from the serial engine. A six-bit interrupt mask selects which status bits drive the single interrupt output. Register decoding happens outside the block, so every command and write arrives as a one-cycle strobe.

Top module: `dual_gran_fifo`

## Requirements
- R1: After reset both FIFOs are empty, and the granularity mode, the completion flags and the interrupt mask are all 0. `status` reads 9'h018 and `irq` is 0. Status layout: bit 0 tx_done, bit 1 rx_done, bit 2 rx_avail, bit 3 tx_avail, bit 4 rx_empty, bit 5 tx_full, bits 7:6 zero, bit 8 granularity mode.
- R2: With the mode at 0, the threshold is 1 byte:
  - tx_full = no free TX byte
  - tx_avail = at least one free TX byte
  - rx_empty = no stored RX byte
  - rx_avail = at least one stored RX byte
- R3: With the mode at 1, the threshold is 4 bytes:
  - tx_full = fewer than 4 free TX bytes
  - tx_avail = at least 4 free TX bytes
  - rx_empty = fewer than 4 stored RX bytes
  - rx_avail = at least 4 stored RX bytes
- R4: The mode changes on the edge after a command pulse.
  - `cmd_word_mode` sets the mode to 1.
  - `cmd_byte_mode` clears it to 0, and wins if both pulses arrive together.
  - The mode is shown on `x4_mode` and in status bit 8.
- R5: The byte streams keep FIFO order.
  - `tx_byte_ready` is high when at least one TX byte is free and `tx_word_valid` is low.
  - `rx_byte_valid` is high when at least one RX byte is stored and `rx_word_ready` is low.
  - `rx_byte_data` is the oldest stored byte.
- R6: A word write pushes 4 bytes, bits 7:0 first. `tx_word_ready` is high only when at least 4 TX bytes are free. A word offered without ready stores no byte at all.
- R7: `rx_word_valid` is high when at least 4 RX bytes are stored. `rx_word_data` holds the 4 oldest bytes, the oldest in bits 7:0. An accepted word removes all four.
- R8: Engine side:
  - `eng_tx_valid` is high when the TX FIFO holds a byte, and `eng_tx_data` is the oldest TX byte.
  - `eng_rx_ready` is high when the RX FIFO has a free byte.
  - A push and a pop on the same FIFO may happen in the same cycle.
- R9: tx_done is set on the edge after an `eng_tx_all` pulse and stays set until cleared.
- R10: rx_done sets only after an `eng_rx_all` pulse has been seen and the RX FIFO is empty at a clock edge. While bytes remain, the flag waits for them to drain, then stays set until cleared.
- R11: The completion flags clear on the edge after either of two events:
  - `done_clr_we` with a 1 in `done_clr_bits` (bit 0 for tx_done, bit 1 for rx_done);
  - a `count_wr` pulse, which clears both flags and any pending rx_done.
  A clear wins over a set in the same cycle.
- R12: `ier_we` loads `ier_q` from `ier_wdata`, with bit n enabling status bit n for n = 0..5. `irq` is the OR of the enabled status bits and follows status within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_byte_valid | input | 1 | Bus offers one TX byte |
| tx_byte_data | input | 8 | TX byte |
| tx_byte_ready | output | 1 | TX byte can be taken |
| tx_word_valid | input | 1 | Bus offers four TX bytes |
| tx_word_data | input | 8*LANES | TX word, first byte in bits 7:0 |
| tx_word_ready | output | 1 | TX word can be taken |
| eng_tx_valid | output | 1 | TX byte available to engine |
| eng_tx_data | output | 8 | Oldest TX byte |
| eng_tx_ready | input | 1 | Engine takes the TX byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | RX FIFO can take a byte |
| rx_byte_valid | output | 1 | RX byte available to bus |
| rx_byte_data | output | 8 | Oldest RX byte |
| rx_byte_ready | input | 1 | Bus takes one RX byte |
| rx_word_valid | output | 1 | Four RX bytes available |
| rx_word_data | output | 8*LANES | Four oldest RX bytes, oldest in bits 7:0 |
| rx_word_ready | input | 1 | Bus takes four RX bytes |
| cmd_word_mode | input | 1 | Pulse: set 4-byte flag granularity |
| cmd_byte_mode | input | 1 | Pulse: set 1-byte flag granularity |
| ier_we | input | 1 | Load interrupt mask |
| ier_wdata | input | 6 | New interrupt mask |
| ier_q | output | 6 | Current interrupt mask |
| done_clr_we | input | 1 | Write-one-to-clear strobe for completion flags |
| done_clr_bits | input | 2 | Bit 0 clears tx_done, bit 1 clears rx_done |
| count_wr | input | 1 | Transfer byte count rewritten; clears both flags |
| eng_tx_all | input | 1 | Pulse: all frames transmitted |
| eng_rx_all | input | 1 | Pulse: all frames received |
| x4_mode | output | 1 | Current flag granularity (1 = 4 bytes) |
| status | output | 9 | Status word, layout in R1 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these properties on every cycle:
- No FIFO is pushed past its capacity or popped below zero.
- A byte-mode command always leaves the mode cleared.
- In 4-byte mode, an available TX flag guarantees that a word write can be taken.
- A word refused for lack of room leaves the TX count unchanged.
- The completion flags stay set unless a clear arrives.
- rx_done rises only from an empty receive FIFO.
- An all-zero mask keeps `irq` low.

Other behaviours can only be shown by the bench's scenarios against its byte-queue model: FIFO order across mixed byte and word traffic, little-endian packing, the exact 3-, 4- and 5-free thresholds, a clear arriving in the same cycle as a set, and rx_done waiting until the last queued byte has drained.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int STAT_W = 9;
  localparam int IRQ_W  = 6;

  // bit positions inside the status word
  localparam int ST_TX_DONE  = 0;
  localparam int ST_RX_DONE  = 1;
  localparam int ST_RX_AVAIL = 2;
  localparam int ST_TX_AVAIL = 3;
  localparam int ST_RX_EMPTY = 4;
  localparam int ST_TX_FULL  = 5;
  localparam int ST_X4       = 8;

  typedef struct packed {
    logic tx_full;
    logic rx_empty;
    logic tx_avail;
    logic rx_avail;
  } dgf_flags_t;
endpackage

// File: rtl/dgf_byte_fifo.sv
module dgf_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NW-1:0]      push_n,
  input  logic [8*LANES-1:0] push_data,
  input  logic [NW-1:0]      pop_n,
  output logic [8*LANES-1:0] head_data,
  output logic [CW-1:0]      count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // several lanes may be written in the same cycle
  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (NW'(k) < push_n) mem[wr_ptr + AW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_n);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_head
    assign head_data[8*g +: 8] = mem[rd_ptr + AW'(g)];
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(push_n) <= CW'(DEPTH) - count);
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);
endmodule

// File: rtl/dgf_flags.sv
module dgf_flags
  import dgf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       [CW-1:0] tx_cnt,
  input  logic       [CW-1:0] rx_cnt,
  input  logic                x4,
  output dgf_flags_t          flags
);
  logic [CW-1:0] tx_free, thr;

  always_comb begin
    tx_free        = CW'(DEPTH) - tx_cnt;
    thr            = x4 ? CW'(LANES) : CW'(1);
    flags.tx_avail = tx_free >= thr;
    flags.tx_full  = tx_free <  thr;
    flags.rx_avail = rx_cnt  >= thr;
    flags.rx_empty = rx_cnt  <  thr;
  end
endmodule

// File: rtl/dgf_status.sv
module dgf_status
  import dgf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_word_mode,
  input  logic              cmd_byte_mode,
  input  logic              ier_we,
  input  logic [IRQ_W-1:0]  ier_wdata,
  input  logic              done_clr_we,
  input  logic [1:0]        done_clr_bits,
  input  logic              count_wr,
  input  logic              eng_tx_all,
  input  logic              eng_rx_all,
  input  logic              rx_drained,
  input  dgf_flags_t        flags,
  output logic              x4,
  output logic [IRQ_W-1:0]  ier_q,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic tx_done, rx_done, rx_pend;
  logic clr_tx, clr_rx;

  assign clr_tx = count_wr | (done_clr_we & done_clr_bits[0]);
  assign clr_rx = count_wr | (done_clr_we & done_clr_bits[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x4      <= 1'b0;
      ier_q   <= '0;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_pend <= 1'b0;
    end else begin
      if (cmd_byte_mode)      x4 <= 1'b0;
      else if (cmd_word_mode) x4 <= 1'b1;
      if (ier_we) ier_q <= ier_wdata;
      tx_done <= clr_tx ? 1'b0 : (tx_done | eng_tx_all);
      rx_pend <= clr_rx ? 1'b0 : (rx_pend | eng_rx_all);
      rx_done <= clr_rx ? 1'b0 : (rx_done | ((rx_pend | eng_rx_all) & rx_drained));
    end
  end

  always_comb begin
    status              = '0;
    status[ST_TX_DONE]  = tx_done;
    status[ST_RX_DONE]  = rx_done;
    status[ST_RX_AVAIL] = flags.rx_avail;
    status[ST_TX_AVAIL] = flags.tx_avail;
    status[ST_RX_EMPTY] = flags.rx_empty;
    status[ST_TX_FULL]  = flags.tx_full;
    status[ST_X4]       = x4;
    irq                 = |(status[IRQ_W-1:0] & ier_q);
  end

  assert_byte_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_byte_mode |=> !x4);
  assert_tx_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_tx) |=> tx_done);
  assert_rx_from_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_drained));
  assert_rx_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_rx) |=> rx_done);
  assert_mask_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q == '0) |-> !irq);
endmodule

// File: rtl/dual_gran_fifo.sv
module dual_gran_fifo
  import dgf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_byte_valid,
  input  logic [7:0]         tx_byte_data,
  output logic               tx_byte_ready,
  input  logic               tx_word_valid,
  input  logic [8*LANES-1:0] tx_word_data,
  output logic               tx_word_ready,
  output logic               eng_tx_valid,
  output logic [7:0]         eng_tx_data,
  input  logic               eng_tx_ready,
  input  logic               eng_rx_valid,
  input  logic [7:0]         eng_rx_data,
  output logic               eng_rx_ready,
  output logic               rx_byte_valid,
  output logic [7:0]         rx_byte_data,
  input  logic               rx_byte_ready,
  output logic               rx_word_valid,
  output logic [8*LANES-1:0] rx_word_data,
  input  logic               rx_word_ready,
  input  logic               cmd_word_mode,
  input  logic               cmd_byte_mode,
  input  logic               ier_we,
  input  logic [5:0]         ier_wdata,
  output logic [5:0]         ier_q,
  input  logic               done_clr_we,
  input  logic [1:0]         done_clr_bits,
  input  logic               count_wr,
  input  logic               eng_tx_all,
  input  logic               eng_rx_all,
  output logic               x4_mode,
  output logic [8:0]         status,
  output logic               irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int NW = $clog2(LANES + 1);
  localparam int WW = 8 * LANES;

  logic [CW-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
  logic [NW-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [WW-1:0] tx_push_data, rx_push_data, tx_head, rx_head;
  logic          tx_word_acc, tx_byte_acc, eng_tx_acc, eng_rx_acc;
  logic          rx_word_acc, rx_byte_acc;
  dgf_flags_t    flags;

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign rx_free = CW'(DEPTH) - rx_cnt;

  // bus -> TX FIFO: a word has priority over a byte
  assign tx_word_ready = tx_free >= CW'(LANES);
  assign tx_byte_ready = (tx_free != '0) && !tx_word_valid;
  assign tx_word_acc   = tx_word_valid && tx_word_ready;
  assign tx_byte_acc   = tx_byte_valid && tx_byte_ready;
  assign tx_push_n     = tx_word_acc ? NW'(LANES) : (tx_byte_acc ? NW'(1) : '0);
  assign tx_push_data  = tx_word_acc ? tx_word_data : WW'(tx_byte_data);

  // TX FIFO -> engine
  assign eng_tx_valid  = tx_cnt != '0;
  assign eng_tx_data   = tx_head[7:0];
  assign eng_tx_acc    = eng_tx_valid && eng_tx_ready;
  assign tx_pop_n      = eng_tx_acc ? NW'(1) : '0;

  // engine -> RX FIFO
  assign eng_rx_ready  = rx_free != '0;
  assign eng_rx_acc    = eng_rx_valid && eng_rx_ready;
  assign rx_push_n     = eng_rx_acc ? NW'(1) : '0;
  assign rx_push_data  = WW'(eng_rx_data);

  // RX FIFO -> bus: a word has priority over a byte
  assign rx_word_valid = rx_cnt >= CW'(LANES);
  assign rx_byte_valid = (rx_cnt != '0) && !rx_word_ready;
  assign rx_word_data  = rx_head;
  assign rx_byte_data  = rx_head[7:0];
  assign rx_word_acc   = rx_word_valid && rx_word_ready;
  assign rx_byte_acc   = rx_byte_valid && rx_byte_ready;
  assign rx_pop_n      = rx_word_acc ? NW'(LANES) : (rx_byte_acc ? NW'(1) : '0);

  dgf_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_fifo (
    .clk, .rst_n, .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop_n), .head_data(tx_head), .count(tx_cnt));

  dgf_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_fifo (
    .clk, .rst_n, .push_n(rx_push_n), .push_data(rx_push_data),
    .pop_n(rx_pop_n), .head_data(rx_head), .count(rx_cnt));

  dgf_flags #(.DEPTH(DEPTH), .LANES(LANES)) u_flags (
    .tx_cnt, .rx_cnt, .x4(x4_mode), .flags);

  dgf_status u_status (
    .clk, .rst_n, .cmd_word_mode, .cmd_byte_mode, .ier_we, .ier_wdata,
    .done_clr_we, .done_clr_bits, .count_wr, .eng_tx_all, .eng_rx_all,
    .rx_drained(rx_cnt == '0), .flags, .x4(x4_mode), .ier_q, .status, .irq);

  assert_x4_word_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (x4_mode && status[ST_TX_AVAIL]) |-> tx_word_ready);
  assert_word_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_word_valid && !tx_word_ready && !eng_tx_acc) |=> $stable(tx_cnt));
endmodule

// File: tb/dual_gran_fifo_tb.sv
`timescale 1ns/1ps
module dual_gran_fifo_tb;
  localparam int DEPTH = 16;
  localparam int LANES = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tx_byte_valid, tx_byte_ready, tx_word_valid, tx_word_ready;
  logic [7:0]  tx_byte_data, eng_tx_data, eng_rx_data, rx_byte_data;
  logic [31:0] tx_word_data, rx_word_data;
  logic        eng_tx_valid, eng_tx_ready, eng_rx_valid, eng_rx_ready;
  logic        rx_byte_valid, rx_byte_ready, rx_word_valid, rx_word_ready;
  logic        cmd_word_mode, cmd_byte_mode, ier_we, done_clr_we, count_wr;
  logic [5:0]  ier_wdata, ier_q;
  logic [1:0]  done_clr_bits;
  logic        eng_tx_all, eng_rx_all, x4_mode, irq;
  logic [8:0]  status;

  int checks = 0, fails = 0;
  logic [7:0] txq[$], rxq[$];
  bit m_x4, m_txd, m_rxd, m_pend;
  logic [5:0] m_ier;

  always #2 clk = ~clk;

  dual_gran_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_dut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    tx_byte_valid = 0; tx_byte_data = 0; tx_word_valid = 0; tx_word_data = 0;
    eng_tx_ready = 0; eng_rx_valid = 0; eng_rx_data = 0;
    rx_byte_ready = 0; rx_word_ready = 0; cmd_word_mode = 0; cmd_byte_mode = 0;
    ier_we = 0; ier_wdata = 0; done_clr_we = 0; done_clr_bits = 0;
    count_wr = 0; eng_tx_all = 0; eng_rx_all = 0;
  endtask

  function automatic logic [8:0] exp_status();
    int tf = DEPTH - txq.size();
    int rs = rxq.size();
    int thr = m_x4 ? 4 : 1;
    return {m_x4, 2'b00, tf < thr, rs < thr, tf >= thr, rs >= thr, m_rxd, m_txd};
  endfunction

  // Inputs are already driven (at a negedge); check, advance model, clock.
  task automatic cycle();
    int tf, rs;
    bit e_txw, e_txb, e_etx, e_erx, e_rxw, e_rxb, clr_t, clr_r;
    logic [8:0] st;
    #1;
    tf = DEPTH - txq.size(); rs = rxq.size();
    e_txw = tf >= 4; e_txb = (tf >= 1) && !tx_word_valid;
    e_etx = txq.size() >= 1; e_erx = rs < DEPTH;
    e_rxw = rs >= 4; e_rxb = (rs >= 1) && !rx_word_ready;
    st = exp_status();
    chk(m_x4 ? "R3" : "R2", "flags", 32'(status[5:2]), 32'(st[5:2]));
    chk("R4", "mode bit", {status[8], x4_mode}, {st[8], st[8]});
    chk("R9 R11", "tx_done", 32'(status[0]), 32'(st[0]));
    chk("R10 R11", "rx_done", 32'(status[1]), 32'(st[1]));
    chk("R12", "irq", 32'(irq), 32'(|(st[5:0] & m_ier)));
    chk("R12", "ier_q", 32'(ier_q), 32'(m_ier));
    chk("R5", "byte ready/valid", {tx_byte_ready, rx_byte_valid}, {e_txb, e_rxb});
    chk("R6", "tx_word_ready", 32'(tx_word_ready), 32'(e_txw));
    chk("R7", "rx_word_valid", 32'(rx_word_valid), 32'(e_rxw));
    chk("R8", "engine valid/ready", {eng_tx_valid, eng_rx_ready}, {e_etx, e_erx});
    if (e_etx) chk("R8", "eng_tx_data", 32'(eng_tx_data), 32'(txq[0]));
    if (e_rxb) chk("R5", "rx_byte_data", 32'(rx_byte_data), 32'(rxq[0]));
    if (e_rxw) chk("R7", "rx_word_data", rx_word_data, {rxq[3], rxq[2], rxq[1], rxq[0]});
    // model next state from pre-edge values
    clr_t = count_wr || (done_clr_we && done_clr_bits[0]);
    clr_r = count_wr || (done_clr_we && done_clr_bits[1]);
    m_txd  = clr_t ? 0 : (m_txd | eng_tx_all);
    m_rxd  = clr_r ? 0 : (m_rxd | ((m_pend | eng_rx_all) && rs == 0));
    m_pend = clr_r ? 0 : (m_pend | eng_rx_all);
    if (cmd_byte_mode) m_x4 = 0; else if (cmd_word_mode) m_x4 = 1;
    if (ier_we) m_ier = ier_wdata;
    if (e_etx && eng_tx_ready) void'(txq.pop_front());
    if (tx_word_valid && e_txw) begin
      for (int k = 0; k < 4; k++) txq.push_back(tx_word_data[8*k +: 8]);
    end else if (tx_byte_valid && e_txb) txq.push_back(tx_byte_data);
    if (rx_word_ready && e_rxw) begin
      for (int k = 0; k < 4; k++) void'(rxq.pop_front());
    end else if (rx_byte_ready && e_rxb) void'(rxq.pop_front());
    if (eng_rx_valid && e_erx) rxq.push_back(eng_rx_data);
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    idle();
    m_ier = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "status", 32'(status), 32'h018);
    chk("R1", "irq/x4/ier", {irq, x4_mode, ier_q}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    cycle();

    // R4: set, then both together -> cleared
    cmd_word_mode = 1; cycle();
    chk("R4", "word cmd sets mode", 32'(x4_mode), 32'd1);
    cmd_word_mode = 1; cmd_byte_mode = 1; cycle();
    chk("R4", "byte cmd wins", 32'(x4_mode), 32'd0);

    // R3: x4 thresholds at 12/13 stored TX bytes, dropped word
    cmd_word_mode = 1; cycle();
    for (int i = 0; i < 13; i++) begin
      tx_byte_valid = 1; tx_byte_data = 8'(8'h30 + i); cycle();
      if (i == 11) chk("R3", "tx_avail at 4 free", 32'(status[3]), 32'd1);
    end
    chk("R3", "tx_full at 3 free", 32'(status[5]), 32'd1);
    tx_word_valid = 1; tx_word_data = 32'hDEADBEEF; cycle();
    chk("R6", "dropped word keeps count", 32'(status[5]), 32'd1);
    for (int i = 0; i < 14; i++) begin eng_tx_ready = 1; cycle(); end
    chk("R8", "tx drained", 32'(eng_tx_valid), 32'd0);

    // R10: rx_done waits for drain; R11 clears
    for (int i = 0; i < 2; i++) begin
      eng_rx_valid = 1; eng_rx_data = 8'(8'hA0 + i); cycle();
    end
    eng_rx_all = 1; cycle();
    cycle();
    chk("R10", "rx_done held while bytes remain", 32'(status[1]), 32'd0);
    rx_byte_ready = 1; cycle();
    rx_byte_ready = 1; cycle();
    cycle();
    chk("R10", "rx_done after drain", 32'(status[1]), 32'd1);
    eng_tx_all = 1; cycle();
    chk("R9", "tx_done set", 32'(status[0]), 32'd1);
    done_clr_we = 1; done_clr_bits = 2'b01; cycle();
    chk("R11", "w1c tx_done only", 32'(status[1:0]), 32'd2);
    count_wr = 1; eng_tx_all = 1; cycle();
    chk("R11", "clear wins over set", 32'(status[1:0]), 32'd0);
    ier_we = 1; ier_wdata = 6'b001000; cycle();
    chk("R12", "irq from tx_avail", 32'(irq), 32'd1);

    // R7: word read packing
    cmd_byte_mode = 1; cycle();
    for (int i = 0; i < 5; i++) begin
      eng_rx_valid = 1; eng_rx_data = 8'(8'h11 * (i + 1)); cycle();
    end
    rx_word_ready = 1; cycle();
    chk("R7", "one byte left after word read", 32'(status[2]), 32'd1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      tx_byte_valid = ($urandom % 100) < 40; tx_byte_data = 8'($urandom);
      tx_word_valid = ($urandom % 100) < 15; tx_word_data = $urandom;
      eng_tx_ready  = ($urandom % 100) < 50;
      eng_rx_valid  = ($urandom % 100) < 50; eng_rx_data = 8'($urandom);
      rx_byte_ready = ($urandom % 100) < 40;
      rx_word_ready = ($urandom % 100) < 15;
      cmd_word_mode = ($urandom % 100) < 3;
      cmd_byte_mode = ($urandom % 100) < 3;
      ier_we = ($urandom % 100) < 5; ier_wdata = 6'($urandom);
      eng_tx_all = ($urandom % 100) < 3;
      eng_rx_all = ($urandom % 100) < 3;
      done_clr_we = ($urandom % 100) < 4; done_clr_bits = 2'($urandom);
      count_wr = ($urandom % 100) < 2;
      cycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule